// File: doc/BRIEF.md
# Register Save-Restore Descriptor Engine

This block walks a contiguous run of descriptors held in an internal table and carries out each descriptor's operation on a target register through a simple bus master port. A descriptor holds a target address, a 32-bit data word, a size code, one enable bit for the save direction, one for the restore direction, and a kind code. Depending on its kind, a descriptor can copy a register into its data word, write the data word back, merge the data word into the register with OR or AND, wait for a number of cycles, or poll the register until a masked condition holds.

Software or a power controller fills the table through a load port. It then issues one group command, which gives the direction (save or restore), the first and last index, a traversal order for each direction, an accepted address window and a timeout budget. The engine stays busy until the last descriptor of the run completes. At that point it pulses `done`. If an address falls outside the window, a bus response reports an error, or the budget runs out, the engine stops early. In that case it pulses `done` together with `done_err` and holds the cause and the failing index until the next command.

Top module: `desc_sr_engine`

## Requirements
- R1: Kind 0 in save direction reads the target and writes the read value, masked to the size, into the descriptor's data word. In restore direction it writes the data word, masked to the size, to the target.
- R2: Kind 1 writes the data word, masked to the size, to the target in either direction.
- R3: Kind 2 reads the target, ORs the masked read value with the data word and writes the result back. Kind 3 does the same with AND. The data word is left unchanged.
- R4: Kind 4 makes no bus access. Alone in a group with count N greater than 0, it keeps `busy` high for exactly N+1 cycles.
- R5: Kind 5 re-reads the target until (read & data) == 0. Kind 6 re-reads it until (read & data) != 0. Each poll is one read.
- R6: Size code 0 selects the low 8 bits and code 1 the low 16 bits. Codes 2 and 3 select all 32 bits. The code is driven on `m_size`, and read and write values are zero-extended from the selected width.
- R7: A descriptor whose enable bit for the current direction is 0 is skipped, with no bus access and no change to its data word.
- R8: If the order bit of the current direction (`cmd_sv_rev` for save, `cmd_rt_rev` for restore) is 0, indices run from `cmd_first` up to `cmd_last`. If it is 1, they run from `cmd_last` down to `cmd_first`.
- R9: If a non-delay, enabled descriptor's address is below `cmd_lo` or above `cmd_hi`, the group is aborted without a bus access. `err_addr` is set and `err_idx` records that descriptor's index.
- R10: A bus response with `m_err` high aborts the group. `err_bus` is set and `err_idx` records the index.
- R11: With `cmd_tmo` = T > 0, a group still busy after T cycles is aborted and `err_timeout` is set. T = 0 disables the limit.
- R12: Kind codes 7 and above are no-ops.
- R13: `busy` is high from the cycle after an accepted command until completion. `done` pulses for one cycle while `busy` is low, and `done_err` pulses with it only on an abort. Error flags hold until the next command and are cleared when it is accepted. A request stays asserted with a stable address until `m_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write a descriptor (ignored while busy) |
| cfg_idx | input | IW | Descriptor index to write |
| cfg_addr | input | AW | Target address |
| cfg_data | input | 32 | Data word |
| cfg_size | input | 2 | Size code |
| cfg_sv_en | input | 1 | Enable in save direction |
| cfg_rt_en | input | 1 | Enable in restore direction |
| cfg_kind | input | 3 | Kind code |
| view_idx | input | IW | Descriptor index to observe |
| view_data | output | 32 | Data word of the observed descriptor |
| cmd_valid | input | 1 | Start a group (accepted while not busy) |
| cmd_restore | input | 1 | 1 = restore, 0 = save |
| cmd_sv_rev | input | 1 | Reverse order for save |
| cmd_rt_rev | input | 1 | Reverse order for restore |
| cmd_first | input | IW | First index of the run |
| cmd_last | input | IW | Last index of the run |
| cmd_lo | input | AW | Lowest accepted address |
| cmd_hi | input | AW | Highest accepted address |
| cmd_tmo | input | TW | Cycle budget, 0 = unlimited |
| m_req | output | 1 | Bus request |
| m_addr | output | AW | Bus address |
| m_size | output | 2 | Bus size code |
| m_we | output | 1 | Bus write |
| m_wdata | output | 32 | Bus write data |
| m_rdata | input | 32 | Bus read data |
| m_ready | input | 1 | Transfer complete |
| m_err | input | 1 | Transfer failed |
| busy | output | 1 | Group in progress |
| done | output | 1 | Group finished pulse |
| done_err | output | 1 | Group aborted pulse |
| err_addr | output | 1 | Address window fault |
| err_bus | output | 1 | Bus fault |
| err_timeout | output | 1 | Budget exceeded |
| err_idx | output | IW | Index at abort |

## Verification
A corrupted index register shows up at the bus port within one transfer, as a wrong address or a wrong final register value. A corrupted kind or direction decode shows up as a wrong target value or a wrong data word at the next completion. A stuck delay or poll counter shows as a `busy` length off by a cycle or as an unexpected poll read count. A broken window or budget comparison shows as a missing or spurious error flag together with `done_err` in the cycle the group ends.

// File: rtl/desc_sr_engine.sv
module desc_sr_engine #(
  parameter int NDESC = 16,
  parameter int AW    = 32,
  parameter int TW    = 32,
  localparam int IW   = (NDESC > 1) ? $clog2(NDESC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [AW-1:0] cfg_addr,
  input  logic [31:0]   cfg_data,
  input  logic [1:0]    cfg_size,
  input  logic          cfg_sv_en,
  input  logic          cfg_rt_en,
  input  logic [2:0]    cfg_kind,
  input  logic [IW-1:0] view_idx,
  output logic [31:0]   view_data,
  input  logic          cmd_valid,
  input  logic          cmd_restore,
  input  logic          cmd_sv_rev,
  input  logic          cmd_rt_rev,
  input  logic [IW-1:0] cmd_first,
  input  logic [IW-1:0] cmd_last,
  input  logic [AW-1:0] cmd_lo,
  input  logic [AW-1:0] cmd_hi,
  input  logic [TW-1:0] cmd_tmo,
  output logic          m_req,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic          m_we,
  output logic [31:0]   m_wdata,
  input  logic [31:0]   m_rdata,
  input  logic          m_ready,
  input  logic          m_err,
  output logic          busy,
  output logic          done,
  output logic          done_err,
  output logic          err_addr,
  output logic          err_bus,
  output logic          err_timeout,
  output logic [IW-1:0] err_idx
);

  typedef enum logic [2:0] {S_IDLE, S_EVAL, S_RD, S_WR, S_DLY} st_t;

  logic [AW-1:0] t_addr [NDESC];
  logic [31:0]   t_data [NDESC];
  logic [1:0]    t_size [NDESC];
  logic          t_sv   [NDESC];
  logic          t_rt   [NDESC];
  logic [2:0]    t_kind [NDESC];

  st_t           st;
  logic [IW-1:0] cur, first_q, last_q;
  logic          rest_q, rev_q;
  logic [AW-1:0] lo_q, hi_q;
  logic [TW-1:0] tmo_q, timer;
  logic [31:0]   cnt, wbuf;

  logic [AW-1:0] d_addr;
  logic [31:0]   d_data, smask, rmask;
  logic [1:0]    d_size;
  logic [2:0]    d_kind;
  logic          d_en, skip, out_win, tmo_hit, f_addr, f_bus, rd_ok, poll_ok, step, at_end;

  assign d_addr = t_addr[cur];
  assign d_data = t_data[cur];
  assign d_size = t_size[cur];
  assign d_kind = t_kind[cur];
  assign d_en   = rest_q ? t_rt[cur] : t_sv[cur];

  assign smask = (d_size == 2'd0) ? 32'h0000_00FF :
                 (d_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign rmask = m_rdata & smask;

  assign skip    = !d_en || (d_kind == 3'd7);
  assign out_win = (d_addr < lo_q) || (d_addr > hi_q);
  assign tmo_hit = (st != S_IDLE) && (tmo_q != '0) && (timer >= tmo_q);
  assign f_addr  = (st == S_EVAL) && !skip && (d_kind != 3'd4) && out_win;
  assign f_bus   = ((st == S_RD) || (st == S_WR)) && m_ready && m_err;
  assign rd_ok   = (st == S_RD) && m_ready && !m_err;
  assign poll_ok = (d_kind == 3'd5) ? ((rmask & d_data) == 32'd0) : ((rmask & d_data) != 32'd0);
  assign at_end  = (cur == (rev_q ? first_q : last_q));

  assign step = ((st == S_EVAL) && !f_addr && (skip || (d_kind == 3'd4 && d_data == 32'd0))) ||
                (rd_ok && (d_kind == 3'd0 || ((d_kind == 3'd5 || d_kind == 3'd6) && poll_ok))) ||
                ((st == S_WR) && m_ready && !m_err) ||
                ((st == S_DLY) && (cnt <= 32'd1));

  assign m_req   = (st == S_RD) || (st == S_WR);
  assign m_we    = (st == S_WR);
  assign m_addr  = d_addr;
  assign m_size  = d_size;
  assign m_wdata = wbuf;
  assign busy    = (st != S_IDLE);
  assign view_data = t_data[view_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDESC; i++) begin
        t_addr[i] <= '0;
        t_data[i] <= '0;
        t_size[i] <= '0;
        t_sv[i]   <= 1'b0;
        t_rt[i]   <= 1'b0;
        t_kind[i] <= '0;
      end
    end else if (st == S_IDLE) begin
      if (cfg_we) begin
        t_addr[cfg_idx] <= cfg_addr;
        t_data[cfg_idx] <= cfg_data;
        t_size[cfg_idx] <= cfg_size;
        t_sv[cfg_idx]   <= cfg_sv_en;
        t_rt[cfg_idx]   <= cfg_rt_en;
        t_kind[cfg_idx] <= cfg_kind;
      end
    end else if (rd_ok && !tmo_hit && d_kind == 3'd0 && !rest_q) begin
      t_data[cur] <= rmask;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cur <= '0; first_q <= '0; last_q <= '0;
      rest_q <= 1'b0; rev_q <= 1'b0;
      lo_q <= '0; hi_q <= '0; tmo_q <= '0; timer <= '0;
      cnt <= '0; wbuf <= '0;
      done <= 1'b0; done_err <= 1'b0;
      err_addr <= 1'b0; err_bus <= 1'b0; err_timeout <= 1'b0; err_idx <= '0;
    end else begin
      done     <= 1'b0;
      done_err <= 1'b0;
      if (st == S_IDLE) begin
        if (cmd_valid) begin
          rest_q  <= cmd_restore;
          rev_q   <= cmd_restore ? cmd_rt_rev : cmd_sv_rev;
          cur     <= (cmd_restore ? cmd_rt_rev : cmd_sv_rev) ? cmd_last : cmd_first;
          first_q <= cmd_first;
          last_q  <= cmd_last;
          lo_q    <= cmd_lo;
          hi_q    <= cmd_hi;
          tmo_q   <= cmd_tmo;
          timer   <= '0;
          err_addr <= 1'b0; err_bus <= 1'b0; err_timeout <= 1'b0; err_idx <= '0;
          st      <= S_EVAL;
        end
      end else begin
        timer <= timer + 1'b1;
        if (tmo_hit || f_addr || f_bus) begin
          err_timeout <= tmo_hit;
          err_addr    <= !tmo_hit && f_addr;
          err_bus     <= !tmo_hit && f_bus;
          err_idx     <= cur;
          done        <= 1'b1;
          done_err    <= 1'b1;
          st          <= S_IDLE;
        end else if (step) begin
          if (at_end) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            cur <= rev_q ? cur - 1'b1 : cur + 1'b1;
            st  <= S_EVAL;
          end
        end else begin
          case (st)
            S_EVAL: begin
              wbuf <= d_data & smask;
              case (d_kind)
                3'd0:    st <= rest_q ? S_WR : S_RD;
                3'd1:    st <= S_WR;
                3'd4: begin
                  cnt <= d_data;
                  st  <= S_DLY;
                end
                default: st <= S_RD;
              endcase
            end
            S_RD: if (rd_ok) begin
              if (d_kind == 3'd2) begin
                wbuf <= (rmask | d_data) & smask;
                st   <= S_WR;
              end else if (d_kind == 3'd3) begin
                wbuf <= (rmask & d_data) & smask;
                st   <= S_WR;
              end
            end
            S_DLY: cnt <= cnt - 1'b1;
            default: ;
          endcase
        end
      end
    end
  end

endmodule

module desc_sr_engine_chk #(
  parameter int AW = 32,
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          m_req,
  input logic          m_ready,
  input logic [AW-1:0] m_addr,
  input logic          busy,
  input logic          done,
  input logic          done_err,
  input logic          err_addr,
  input logic          err_bus,
  input logic          err_timeout,
  input logic [AW-1:0] lo_q,
  input logic [AW-1:0] hi_q,
  input logic [TW-1:0] tmo_q
);
  logic [TW:0] busy_cyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     busy_cyc <= '0;
    else if (!busy) busy_cyc <= '0;
    else            busy_cyc <= busy_cyc + 1'b1;
  end

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ready) |=> ((m_req && $stable(m_addr)) || done));
  // R13
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !m_req);
  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R13
  done_err_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_err |-> (done && (err_addr || err_bus || err_timeout)));
  // R9
  addr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> ((m_addr >= lo_q) && (m_addr <= hi_q)));
  // R9
  one_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_addr, err_bus, err_timeout}));
  // R11
  budget_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && tmo_q != '0) |-> (busy_cyc <= {1'b0, tmo_q}));
endmodule

bind desc_sr_engine desc_sr_engine_chk #(.AW(AW), .TW(TW)) chk_i (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_ready(m_ready), .m_addr(m_addr),
  .busy(busy), .done(done), .done_err(done_err), .err_addr(err_addr),
  .err_bus(err_bus), .err_timeout(err_timeout), .lo_q(lo_q), .hi_q(hi_q), .tmo_q(tmo_q)
);

// File: tb/desc_sr_engine_tb_top.sv
module desc_sr_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          cfg_we = 0, cfg_sv_en = 0, cfg_rt_en = 0;
  logic [IW-1:0] cfg_idx = 0, view_idx = 0, cmd_first = 0, cmd_last = 0, err_idx;
  logic [31:0]   cfg_addr = 0, cfg_data = 0, view_data, cmd_lo = 0, cmd_hi = 0, cmd_tmo = 0;
  logic [1:0]    cfg_size = 0, m_size;
  logic [2:0]    cfg_kind = 0;
  logic          cmd_valid = 0, cmd_restore = 0, cmd_sv_rev = 0, cmd_rt_rev = 0;
  logic          m_req, m_we, m_ready, m_err;
  logic [31:0]   m_addr, m_wdata, m_rdata;
  logic          busy, done, done_err, err_addr, err_bus, err_timeout;

  desc_sr_engine dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .cfg_size(cfg_size), .cfg_sv_en(cfg_sv_en), .cfg_rt_en(cfg_rt_en), .cfg_kind(cfg_kind),
    .view_idx(view_idx), .view_data(view_data),
    .cmd_valid(cmd_valid), .cmd_restore(cmd_restore), .cmd_sv_rev(cmd_sv_rev), .cmd_rt_rev(cmd_rt_rev),
    .cmd_first(cmd_first), .cmd_last(cmd_last), .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_tmo(cmd_tmo),
    .m_req(m_req), .m_addr(m_addr), .m_size(m_size), .m_we(m_we), .m_wdata(m_wdata),
    .m_rdata(m_rdata), .m_ready(m_ready), .m_err(m_err),
    .busy(busy), .done(done), .done_err(done_err), .err_addr(err_addr), .err_bus(err_bus),
    .err_timeout(err_timeout), .err_idx(err_idx)
  );

  // bus target: 0x100..0x13C words, 0x140 read counter, bit 9 set -> error
  logic [31:0] mem [16];
  int unsigned pollc;
  logic        wt;
  assign m_ready = m_req && wt;
  assign m_err   = m_addr[9];
  assign m_rdata = (m_addr == 32'h140) ? pollc : mem[m_addr[5:2]];
  always @(posedge clk) begin
    if (!rst_n) wt <= 1'b0;
    else        wt <= m_req && !wt;
    if (m_req && wt && !m_addr[9]) begin
      if (m_addr == 32'h140) begin
        if (!m_we) pollc <= pollc + 1;
      end else if (m_we) mem[m_addr[5:2]] <= m_wdata;
    end
  end

  int checks = 0, failures = 0;
  int busy_len;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input int idx, input logic [31:0] a, input logic [31:0] d, input logic [1:0] sz,
                      input bit sv, input bit rt, input logic [2:0] k);
    @(negedge clk);
    cfg_we = 1; cfg_idx = idx[IW-1:0]; cfg_addr = a; cfg_data = d; cfg_size = sz;
    cfg_sv_en = sv; cfg_rt_en = rt; cfg_kind = k;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic run(input bit rest, input bit svr, input bit rtr, input int f, input int l,
                     input logic [31:0] lo, input logic [31:0] hi, input logic [31:0] tmo);
    int guard;
    @(negedge clk);
    cmd_valid = 1; cmd_restore = rest; cmd_sv_rev = svr; cmd_rt_rev = rtr;
    cmd_first = f[IW-1:0]; cmd_last = l[IW-1:0]; cmd_lo = lo; cmd_hi = hi; cmd_tmo = tmo;
    @(negedge clk);
    cmd_valid = 0;
    busy_len = 0;
    guard = 0;
    while (!done && guard < 5000) begin
      if (busy) busy_len++;
      @(negedge clk);
      guard++;
    end
    if (guard >= 5000) chk(0, "R13 group never finished", 0, 1);
  endtask

  function automatic string vtag(input logic [135:0] v);
    if (!(v[134] && v[133]) && ((v[135] && !v[133]) || (!v[135] && !v[134]))) return "R7";
    if (v[132:130] == 3'd7) return "R12";
    if (v[129:128] != 2'd2) return "R6";
    if (v[132:130] == 3'd0) return "R1";
    if (v[132:130] == 3'd1) return "R2";
    return "R3";
  endfunction

  // {restore, sv_en, rt_en, kind, size, desc data, initial target, expected target, expected desc data}
  localparam logic [135:0] VEC [11] = '{
    {1'b0, 1'b1, 1'b1, 3'd0, 2'd2, 32'hDEAD_0000, 32'hA5A5_1234, 32'hA5A5_1234, 32'hA5A5_1234},
    {1'b0, 1'b1, 1'b1, 3'd0, 2'd0, 32'hDEAD_0000, 32'hA5A5_1234, 32'hA5A5_1234, 32'h0000_0034},
    {1'b0, 1'b1, 1'b1, 3'd0, 2'd1, 32'hDEAD_0000, 32'hA5A5_1234, 32'hA5A5_1234, 32'h0000_1234},
    {1'b1, 1'b1, 1'b1, 3'd0, 2'd2, 32'hCAFE_F00D, 32'h0000_0000, 32'hCAFE_F00D, 32'hCAFE_F00D},
    {1'b1, 1'b1, 1'b1, 3'd1, 2'd0, 32'h0000_01FF, 32'h1234_5678, 32'h0000_00FF, 32'h0000_01FF},
    {1'b0, 1'b1, 1'b1, 3'd2, 2'd2, 32'h0000_00F0, 32'h0000_0F00, 32'h0000_0FF0, 32'h0000_00F0},
    {1'b1, 1'b1, 1'b1, 3'd3, 2'd2, 32'h0000_0F0F, 32'h0000_FF0F, 32'h0000_0F0F, 32'h0000_0F0F},
    {1'b1, 1'b1, 1'b1, 3'd2, 2'd1, 32'h0000_0010, 32'hABCD_0001, 32'h0000_0011, 32'h0000_0010},
    {1'b1, 1'b1, 1'b1, 3'd7, 2'd2, 32'h0000_0055, 32'h0000_0077, 32'h0000_0077, 32'h0000_0055},
    {1'b1, 1'b1, 1'b0, 3'd1, 2'd2, 32'h0000_0099, 32'h0000_0077, 32'h0000_0077, 32'h0000_0099},
    {1'b0, 1'b0, 1'b1, 3'd0, 2'd2, 32'h0000_0042, 32'h0000_0077, 32'h0000_0077, 32'h0000_0042}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 0;
    pollc = 0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(!busy && !done && !done_err && !m_req, "R13 reset idle", {28'd0, busy, done, done_err, m_req}, 0);
    chk(!err_addr && !err_bus && !err_timeout, "R13 reset flags", {29'd0, err_addr, err_bus, err_timeout}, 0);
    rst_n = 1;

    for (int n = 0; n < 11; n++) begin
      load(0, 32'h100, VEC[n][127:96], VEC[n][129:128], VEC[n][134], VEC[n][133], VEC[n][132:130]);
      @(negedge clk);
      mem[0] = VEC[n][95:64];
      run(VEC[n][135], 0, 0, 0, 0, 32'h100, 32'h13C, 0);
      view_idx = 0;
      #1;
      chk(mem[0] == VEC[n][63:32], vtag(VEC[n]), mem[0], VEC[n][63:32]);
      chk(view_data == VEC[n][31:0], vtag(VEC[n]), view_data, VEC[n][31:0]);
      chk(!done_err, vtag(VEC[n]), {31'd0, done_err}, 0);
    end

    // R4 delay of 30 cycles
    load(1, 32'h0, 30, 2, 1, 1, 3'd4);
    run(1, 0, 0, 1, 1, 32'h100, 32'h13C, 0);
    chk(busy_len == 31 && !done_err, "R4 delay busy length", busy_len, 31);

    // R11 budget smaller than delay aborts, zero and large budgets do not
    run(1, 0, 0, 1, 1, 32'h100, 32'h13C, 20);
    chk(done_err && err_timeout && err_idx == 1, "R11 timeout abort", {err_timeout, 27'd0, err_idx}, 32'h8000_0001);
    run(1, 0, 0, 1, 1, 32'h100, 32'h13C, 40);
    chk(!done_err && !err_timeout, "R11 budget not reached", {31'd0, err_timeout}, 0);

    // R5 poll until bit 2 set, then until low two bits clear
    load(2, 32'h140, 32'h4, 2, 1, 1, 3'd6);
    @(negedge clk); pollc = 0;
    run(0, 0, 0, 2, 2, 32'h100, 32'h140, 0);
    chk(pollc == 5 && !done_err, "R5 poll for nonzero", pollc, 5);
    load(2, 32'h140, 32'h3, 2, 1, 1, 3'd5);
    @(negedge clk); pollc = 1;
    run(0, 0, 0, 2, 2, 32'h100, 32'h140, 0);
    chk(pollc == 5 && !done_err, "R5 poll for zero", pollc, 5);

    // R8 traversal order: three fixed writes to the same word
    load(4, 32'h104, 1, 2, 1, 1, 3'd1);
    load(5, 32'h104, 2, 2, 1, 1, 3'd1);
    load(6, 32'h104, 3, 2, 1, 1, 3'd1);
    run(1, 1, 0, 4, 6, 32'h100, 32'h13C, 0);
    chk(mem[1] == 3, "R8 restore forward", mem[1], 3);
    run(1, 0, 1, 4, 6, 32'h100, 32'h13C, 0);
    chk(mem[1] == 1, "R8 restore reverse", mem[1], 1);
    run(0, 1, 0, 4, 6, 32'h100, 32'h13C, 0);
    chk(mem[1] == 1, "R8 save uses its own order bit", mem[1], 1);
    run(0, 0, 1, 4, 6, 32'h100, 32'h13C, 0);
    chk(mem[1] == 3, "R8 save forward", mem[1], 3);

    // R9 address outside window
    load(4, 32'h108, 32'h11, 2, 1, 1, 3'd1);
    load(5, 32'h300, 32'h22, 2, 1, 1, 3'd1);
    load(6, 32'h10C, 32'h66, 2, 1, 1, 3'd1);
    @(negedge clk); mem[2] = 0; mem[3] = 0;
    run(1, 0, 0, 4, 6, 32'h100, 32'h13C, 0);
    chk(done_err && err_addr && !err_bus && err_idx == 5, "R9 window fault", {err_addr, err_bus, 26'd0, err_idx}, 32'h8000_0005);
    chk(mem[2] == 32'h11 && mem[3] == 0, "R9 abort stops later descriptors", mem[3], 0);

    // R10 bus error response
    load(5, 32'h200, 32'h22, 2, 1, 1, 3'd1);
    run(1, 0, 0, 4, 6, 32'h100, 32'h3FF, 0);
    chk(done_err && err_bus && !err_addr && err_idx == 5, "R10 bus fault", {err_bus, err_addr, 26'd0, err_idx}, 32'h8000_0005);
    chk(mem[3] == 0, "R10 abort stops later descriptors", mem[3], 0);

    // R13 flags cleared by the next good command
    run(1, 0, 0, 4, 4, 32'h100, 32'h13C, 0);
    chk(!done_err && !err_bus && !err_addr && !err_timeout, "R13 flags cleared",
        {29'd0, err_addr, err_bus, err_timeout}, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule